// File: doc/BRIEF.md
# Serial Host Register Port

This block is a synchronous serial slave. It lets a host processor read and write a bank of 8-bit registers over four wires: a chip select, a serial clock, a data input and a data output. All logic runs on the fast system clock. The serial clock, the chip select and the data input pass through synchronizer flops, and their edges are found by oversampling. On the register side the block drives a simple parallel bus with an address, write data, a one-cycle write strobe and a one-cycle read strobe. The register bank answers a read combinationally on the read-data input.

A transaction opens when chip select falls and lasts while it stays low. The host sends a command byte and then a second byte, both least significant bit first. The command byte holds the direction and the register address. For a write, the second byte is the data to store. For a read, the block ignores the second byte on the input. It shifts the register contents out during those eight clocks instead. A static edge-select input sets which serial-clock edge the output data is valid at. The output-enable stays low for the whole of a write and whenever chip select is high.

The system clock must be at least eight times the serial clock rate.

Top module: `sreg_port`

## Requirements
- R1: After reset, `sdo_oe`, `reg_we` and `reg_re` are all low.
- R2: A transaction starts on a high-to-low transition of `cs_n`. `sdi` is sampled on rising `sclk` edges, least significant bit first. In command byte bits 0..7, bit 0 is the direction (1 = read, 0 = write), bits 6..1 are the register address, and bit 7 has no effect. `reg_we` and `reg_re` are never high in the same cycle.
- R3: A write transaction of 16 bits gives exactly one `reg_we` pulse, one system clock wide, after the 16th rising edge is sampled. During that pulse, `reg_addr` carries the address and `reg_wdata` carries the second byte.
- R4: A read transaction gives exactly one `reg_re` pulse, one system clock wide, after the 8th rising edge. During that pulse, `reg_addr` carries the address and `reg_rdata` is captured.
- R5: With `edge_sel` = 1, read bit k (LSB first) changes after a falling `sclk` edge. It is valid at the rising edge of serial bit 9+k (1-based count).
- R6: With `edge_sel` = 0, read bit k changes after a rising `sclk` edge. It is valid at the falling edge that follows rising edge 9+k.
- R7: `sdo_oe` is low while `cs_n` is high and for the whole of a write transaction. In a read it is high from the loading of the read byte until `cs_n` rises.
- R8: If `cs_n` rises before 16 bits have been received, no `reg_we` is issued and the register keeps its old value.
- R9: A read transaction never issues `reg_we`, whatever the host shifts in during the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| edge_sel | input | 1 | Output edge choice: 1 = valid at rising, 0 = valid at falling |
| sdo | output | 1 | Serial read data (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the tri-state pad |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid while reg_re is high |

## Verification
Every one of the 64 addresses is written with an arithmetic data pattern, and bit 7 of the command alternates, so address decoding and the ignored bit are covered together. Every address is then read back in both edge modes. A mismatch in one mode only points at output timing, while a mismatch in both points at decode or data capture. A write cut short after 12 bits must leave the old value and give no strobe. Read frames carry nonzero second bytes, which would expose any stray write strobe.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } dir_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_low,
   input  logic              cs_fall,
   input  logic              rise,
   input  logic              sdi_s,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re
);
   localparam int CMD_W = DATA_W;
   localparam int FRAME = CMD_W + DATA_W;
   localparam int CNT_W = $clog2(FRAME + 1);

   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [CMD_W-1:0] cmd_q, cmd_nx;
   logic [DATA_W-1:0] dat_q, dat_nx;

   always_comb begin
      cmd_nx = cmd_q;
      dat_nx = dat_q;
      for (int i = 0; i < CMD_W; i++)
         if (cnt == CNT_W'(i)) cmd_nx[i] = sdi_s;
      for (int i = 0; i < DATA_W; i++)
         if (cnt == CNT_W'(CMD_W + i)) dat_nx[i] = sdi_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         cmd_q  <= '0;
         dat_q  <= '0;
         reg_we <= 1'b0;
         reg_re <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         if (!cs_low) begin
            active <= 1'b0;
            cnt    <= '0;
         end else if (cs_fall) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (active && rise && cnt < CNT_W'(FRAME)) begin
            cnt   <= cnt + 1'b1;
            cmd_q <= cmd_nx;
            dat_q <= dat_nx;
            if (cnt == CNT_W'(CMD_W-1) && cmd_nx[0] == DIR_READ)
               reg_re <= 1'b1;
            if (cnt == CNT_W'(FRAME-1) && cmd_q[0] == DIR_WRITE)
               reg_we <= 1'b1;
         end
      end
   end

   assign reg_addr  = cmd_q[ADDR_W:1];
   assign reg_wdata = dat_q;
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_low,
   input  logic              load,
   input  logic [DATA_W-1:0] ldata,
   input  logic              rise,
   input  logic              fall,
   input  logic              edge_sel,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int OC_W  = $clog2(DATA_W + 1);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] sh;
   logic [OC_W-1:0]   rc, fc, sel_c;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         sdo_oe <= 1'b0;
         rc     <= '0;
         fc     <= '0;
      end else if (!cs_low) begin
         sdo_oe <= 1'b0;
         rc     <= '0;
         fc     <= '0;
      end else if (load) begin
         sh     <= ldata;
         sdo_oe <= 1'b1;
         rc     <= '0;
         fc     <= '0;
      end else if (sdo_oe) begin
         if (rise && rc != OC_W'(DATA_W)) rc <= rc + 1'b1;
         if (fall && fc != OC_W'(DATA_W)) fc <= fc + 1'b1;
      end
   end

   // edge_sel=1: advance after falling edges; 0: after rising edges.
   // The first counted edge presents bit 0, later ones step the index.
   assign sel_c = edge_sel ? fc : rc;
   assign idx   = (sel_c == '0) ? '0 : IDX_W'(sel_c - 1'b1);
   assign sdo   = sdo_oe & sh[idx];
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              edge_sel,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              reg_re,
   input  logic [DATA_W-1:0] reg_rdata
);
   if (ADDR_W + 1 > DATA_W) begin : g_bad_addr
      $error("ADDR_W plus direction bit must fit in one command byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0] raw_in, syn;
   logic       sclk_s, cs_s, sdi_s;
   logic       sclk_d, cs_d;
   logic       rise, fall, cs_low, cs_fall;

   assign raw_in = {sclk, cs_n, sdi};

   sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   assign {sclk_s, cs_s, sdi_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   assign rise    = sclk_s & ~sclk_d;
   assign fall    = ~sclk_s & sclk_d;
   assign cs_low  = ~cs_s;
   assign cs_fall = ~cs_s & cs_d;

   sreg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
      .rise(rise), .sdi_s(sdi_s), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re)
   );

   sreg_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .load(reg_re),
      .ldata(reg_rdata), .rise(rise), .fall(fall), .edge_sel(edge_sel),
      .sdo(sdo), .sdo_oe(sdo_oe)
   );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk (
   input logic clk,
   input logic rst_n,
   input logic reg_we,
   input logic reg_re,
   input logic sdo_oe,
   input logic cs_low
);
   AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R3
   AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re); // R4
   AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re)); // R2
   AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> !sdo_oe); // R7
   AST_OE_AFTER_RE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> $past(reg_re)); // R4
   AST_WE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> $past(cs_low)); // R8
endmodule

bind sreg_port sreg_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
   .sdo_oe(sdo_oe), .cs_low(cs_low)
);

// File: tb/sreg_port_tb.sv
`timescale 1ns/1ps
module sreg_port_tb;
   localparam int HALF = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, edge_sel = 1'b1;
   logic       sdo, sdo_oe, reg_we, reg_re;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] mem [64];
   int         checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;

   always #2 clk = ~clk;

   sreg_port u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
      .edge_sel(edge_sel), .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_rdata(reg_rdata)
   );

   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (reg_re) re_cnt <= re_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 5) & 255);
   endfunction

   task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                       output logic [7:0] rd, output int oe_bad);
      rd = '0;
      oe_bad = 0;
      cs_n = 1'b0;
      #HALF;
      for (int i = 0; i < nbits; i++) begin
         sdi = (i < 8) ? c[i] : d[i-8];
         #HALF;
         if (c[0] == 1'b0 && sdo_oe) oe_bad++;
         if (c[0] == 1'b1 && i >= 8 && !sdo_oe) oe_bad++;
         if (i >= 8 && edge_sel) rd[i-8] = sdo;
         sclk = 1'b1;
         #HALF;
         if (c[0] == 1'b0 && sdo_oe) oe_bad++;
         if (i >= 8 && !edge_sel) rd[i-8] = sdo;
         sclk = 1'b0;
      end
      #HALF;
      cs_n = 1'b1;
      #(4*HALF);
   endtask

   initial begin
      logic [7:0] rd;
      int         bad, w0, r0;
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      repeat (5) @(posedge clk);
      #1;
      // R1: reset state
      chk(!sdo_oe && !reg_we && !reg_re, "R1 reset outputs", {sdo_oe, reg_we, reg_re}, 0);
      rst_n = 1'b1;
      #(4*HALF);
      chk(!sdo_oe, "R7 idle oe low", sdo_oe, 0);

      // R2/R3: write every address, bit7 of command alternates (ignored)
      for (int a = 0; a < 64; a++) begin
         w0 = we_cnt;
         xfer({a[0], 6'(a), 1'b0}, pat(a), 16, rd, bad);
         chk(we_cnt == w0 + 1 && mem[a] == pat(a), "R3 write strobe/data", mem[a], pat(a));
         chk(bad == 0, "R7 oe low during write", bad, 0);
      end

      // R4/R5/R6/R9: read every address in both edge modes
      for (int m = 0; m < 2; m++) begin
         edge_sel = (m == 0);
         for (int a = 0; a < 64; a++) begin
            w0 = we_cnt;
            r0 = re_cnt;
            xfer({a[1], 6'(a), 1'b1}, 8'hA5, 16, rd, bad);
            if (m == 0) chk(rd == pat(a), "R5 read data rising-valid", rd, pat(a));
            else        chk(rd == pat(a), "R6 read data falling-valid", rd, pat(a));
            chk(re_cnt == r0 + 1, "R4 one read strobe", re_cnt - r0, 1);
            chk(we_cnt == w0, "R9 no write in read", we_cnt - w0, 0);
            chk(bad == 0 && !sdo_oe, "R7 oe during read and after cs", bad, 0);
         end
      end

      // R8: aborted write after 12 bits
      w0 = we_cnt;
      xfer({1'b0, 6'd5, 1'b0}, 8'hEE, 12, rd, bad);
      chk(we_cnt == w0, "R8 no strobe on abort", we_cnt - w0, 0);
      edge_sel = 1'b1;
      xfer({1'b0, 6'd5, 1'b1}, 8'h00, 16, rd, bad);
      chk(rd == pat(5), "R8 register unchanged after abort", rd, pat(5));

      // R2: direction bit decides; address 63 written with bit7 set
      w0 = we_cnt;
      xfer({1'b1, 6'd63, 1'b0}, 8'h3C, 16, rd, bad);
      chk(we_cnt == w0 + 1 && mem[63] == 8'h3C, "R2 decode with bit7 set", mem[63], 8'h3C);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule